// File: doc/BRIEF.md
# Snoop-Hit Modified-Line Write-Back Controller

This block sits on the bus side of a write-back data cache. While an external master holds the address bus, it can probe the cache with a snoop. A lookup outside this block reports whether the probed line is present in the modified state. If it is, and the snoop carries the invalidate qualifier, the controller captures the whole 16-byte line into a small local buffer. It raises the hit-modified flag and pushes the line onto the system bus as four doublewords. When the push ends, it tells the tag store to clear the line.

The system bus can finish the push in one of two ways. It can run one burst cycle paced by burst-ready. It can also run separate single-transfer cycles, each with its own address strobe, paced by plain ready. Plain ready takes precedence when both are seen. The first address strobe of the push always follows one idle clock, so the system can still back the cycle off while it holds the address bus. Back-off floats the bus. When back-off is released, the push restarts from the first doubleword, and the hit-modified flag stays up throughout.

Top module: `snoop_wb_ctrl`

## Requirements
- R1: A snoop (`snp_i`) with `hold_i`, `snp_inv_i` and `lk_hit_mod_i` all high, seen while the controller is idle, sets `hitm_o` from the next clock. It also captures `snp_addr_i` and `lk_line_i`. Doubleword k of the line is `lk_line_i[32k+31:32k]`.
- R2: A snoop is ignored if `hold_i`, `snp_inv_i` or `lk_hit_mod_i` is low. A snoop that arrives while a write-back is in progress is also ignored. In either case `hitm_o`, `ads_o` and the captured line do not change.
- R3: The write-back moves exactly four doublewords. `addr_o` is `{line address, k}`, which puts the byte offsets at 0x0, 0x4, 0x8 and 0xC for k = 0..3. `data_o` carries doubleword k.
- R4: In a burst, one `ads_o` is followed by four `brdy_i` transfers. The next doubleword is presented in the clock after each burst-ready.
- R5: A `rdy_i` on doubleword k < 3 ends that cycle. `ads_o` for doubleword k+1 is raised in the very next clock, with no idle clock in between. `rdy_i` wins over `brdy_i` when both are high.
- R6: Every write-back start, including a restart after back-off, has exactly one clock with no address strobe and no transfer between the accepting edge and the first `ads_o`. Ready inputs in that clock and in the `ads_o` clock are ignored.
- R7: `hitm_o` stays high until the edge where a ready input is seen for doubleword 3. It is low from that edge on.
- R8: `blast_o` is high exactly while doubleword 3 is on the bus after its address strobe.
- R9: `wr_o` and `cache_o` are high for every address-strobe and transfer clock of the write-back.
- R10: `boff_i`, sampled during the idle clock, the strobe clock or a transfer clock, overrides any ready input. From the next clock `float_o` is high and `ads_o`, `wr_o` and `blast_o` are low. After release, the push restarts from doubleword 0 and `hitm_o` stays high.
- R11: In the clock after the final ready, `inval_o` pulses high for one clock, with `inval_addr_o` equal to the captured line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Address bus held by an external master |
| snp_i | input | 1 | Snoop strobe |
| snp_inv_i | input | 1 | Snoop invalidate qualifier |
| snp_addr_i | input | AW-4 | Snooped line address |
| lk_hit_mod_i | input | 1 | Lookup result: line present and modified |
| lk_line_i | input | 128 | Line contents from the data array |
| rdy_i | input | 1 | Plain ready, ends the current cycle |
| brdy_i | input | 1 | Burst ready, one transfer within a burst |
| boff_i | input | 1 | Bus back-off |
| ads_o | output | 1 | Address strobe |
| addr_o | output | AW-2 | Doubleword address |
| data_o | output | 32 | Write data |
| wr_o | output | 1 | Write cycle indicator |
| cache_o | output | 1 | Cacheable-cycle indicator |
| blast_o | output | 1 | Last transfer of the line |
| float_o | output | 1 | Bus outputs floated |
| hitm_o | output | 1 | Snoop hit a modified line |
| inval_o | output | 1 | Clear the line's valid state |
| inval_addr_o | output | AW-4 | Line to invalidate |

## Verification
A wrong doubleword counter is visible on `addr_o` and `data_o` in the very next transfer clock. A count that ends early or late moves the fall of `hitm_o` and the `inval_o` pulse by at least one clock. A sequencer that skips or doubles the dead clock shifts the first `ads_o` by a cycle. A restart that resumes at the wrong doubleword is caught on the first strobe after back-off is released. The bench compares every output against a behavioural model on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/snwb_pkg.sv
package snwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,   // dead clock before a snoop-forced strobe
    ST_ADDR,  // address strobe clock
    ST_XFER,  // waiting for ready / burst-ready
    ST_BOFF   // backed off, bus floated
  } wb_state_e;
endpackage

// File: rtl/snwb_line_buf.sv
module snwb_line_buf #(
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int BW   = $clog2(BEATS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [DW*BEATS-1:0] line_i,
  input  logic [BW-1:0]       sel_i,
  output logic [DW-1:0]       word_o
);
  logic [DW-1:0] ent_q [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_q[g] <= '0;
      else if (load_i) ent_q[g] <= line_i[g*DW +: DW];
    end
  end

  assign word_o = ent_q[sel_i];
endmodule

// File: rtl/snwb_seq.sv
module snwb_seq
  import snwb_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int BW   = $clog2(BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rdy_i,
  input  logic          brdy_i,
  input  logic          boff_i,
  output wb_state_e     state_o,
  output logic [BW-1:0] beat_o,
  output logic          hitm_o,
  output logic          done_o
);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  wb_state_e     st_q, st_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          hitm_q, hitm_d, done_d, done_q;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    hitm_d = hitm_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_GAP;
        beat_d = '0;
        hitm_d = 1'b1;
      end
      ST_GAP:  st_d = boff_i ? ST_BOFF : ST_ADDR;
      ST_ADDR: st_d = boff_i ? ST_BOFF : ST_XFER;
      ST_XFER: begin
        if (boff_i) begin
          st_d = ST_BOFF;
        end else if (rdy_i || brdy_i) begin
          if (beat_q == LAST) begin
            st_d   = ST_IDLE;
            hitm_d = 1'b0;
            done_d = 1'b1;
          end else begin
            beat_d = beat_q + 1'b1;
            // plain ready closes the cycle; burst-ready stays in it
            if (rdy_i) st_d = ST_ADDR;
          end
        end
      end
      ST_BOFF: begin
        beat_d = '0;
        if (!boff_i) st_d = ST_GAP;
      end
      default: st_d = ST_IDLE;
    endcase
    if (boff_i && (st_q inside {ST_GAP, ST_ADDR, ST_XFER})) beat_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      hitm_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      hitm_q <= hitm_d;
      done_q <= done_d;
    end
  end

  assign state_o = st_q;
  assign beat_o  = beat_q;
  assign hitm_o  = hitm_q;
  assign done_o  = done_q;

  p_hitm_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> hitm_q);
  p_gap_then_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GAP && !boff_i) |=> (st_q == ST_ADDR && beat_q == '0));
  p_boff_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BOFF) |-> beat_q == '0 || $past(st_q) != ST_BOFF);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/snoop_wb_ctrl.sv
module snoop_wb_ctrl
  import snwb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int BEATS  = 4,
  localparam int BW    = $clog2(BEATS),
  localparam int BYW   = $clog2(DW / 8),
  localparam int OFF_W = BW + BYW,
  localparam int LW    = DW * BEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              snp_i,
  input  logic              snp_inv_i,
  input  logic [AW-1:OFF_W] snp_addr_i,
  input  logic              lk_hit_mod_i,
  input  logic [LW-1:0]     lk_line_i,
  input  logic              rdy_i,
  input  logic              brdy_i,
  input  logic              boff_i,
  output logic              ads_o,
  output logic [AW-1:BYW]   addr_o,
  output logic [DW-1:0]     data_o,
  output logic              wr_o,
  output logic              cache_o,
  output logic              blast_o,
  output logic              float_o,
  output logic              hitm_o,
  output logic              inval_o,
  output logic [AW-1:OFF_W] inval_addr_o
);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  wb_state_e         st;
  logic [BW-1:0]     beat;
  logic              start, done, on_bus;
  logic [AW-1:OFF_W] laddr_q;
  logic [DW-1:0]     word;

  assign start = (st == ST_IDLE) && snp_i && hold_i && snp_inv_i && lk_hit_mod_i;

  snwb_seq #(.BEATS(BEATS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .rdy_i   (rdy_i),
    .brdy_i  (brdy_i),
    .boff_i  (boff_i),
    .state_o (st),
    .beat_o  (beat),
    .hitm_o  (hitm_o),
    .done_o  (done)
  );

  snwb_line_buf #(.DW(DW), .BEATS(BEATS)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .line_i (lk_line_i),
    .sel_i  (beat),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    laddr_q <= '0;
    else if (start) laddr_q <= snp_addr_i;
  end

  assign on_bus       = (st == ST_ADDR) || (st == ST_XFER);
  assign ads_o        = (st == ST_ADDR);
  assign wr_o         = on_bus;
  assign cache_o      = on_bus;
  assign blast_o      = on_bus && (beat == LAST);
  assign float_o      = (st == ST_BOFF);
  assign addr_o       = {laddr_q, beat};
  assign data_o       = on_bus ? word : '0;
  assign inval_o      = done;
  assign inval_addr_o = laddr_q;

  p_ads_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_o |=> !ads_o);
  p_ads_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_o |-> (wr_o && cache_o));
  p_float_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_o |-> (!ads_o && !wr_o && !blast_o));
  p_hitm_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hitm_o) |-> ($past(blast_o) && ($past(rdy_i) || $past(brdy_i)) && !$past(boff_i)));
  p_inval_after_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |-> (!hitm_o && $past(hitm_o)));
  p_first_strobe_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_o && addr_o[BW-1+BYW:BYW] == '0) |-> ($past(st) == ST_GAP));
  p_hold_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hitm_o && $past(hitm_o) |-> $stable(laddr_q));
endmodule

// File: tb/tb_snoop_wb_ctrl.sv
`timescale 1ns/1ps
module tb_snoop_wb_ctrl;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          hold, snp, inv, hit, rdy, brdy, boff;
  logic [AW-1:4] saddr;
  logic [127:0]  line;
  logic          ads, wr, cache, blast, flt, hitm, invo;
  logic [AW-1:2] addr;
  logic [31:0]   data;
  logic [AW-1:4] iaddr;

  snoop_wb_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .snp_i(snp), .snp_inv_i(inv),
    .snp_addr_i(saddr), .lk_hit_mod_i(hit), .lk_line_i(line), .rdy_i(rdy),
    .brdy_i(brdy), .boff_i(boff), .ads_o(ads), .addr_o(addr), .data_o(data),
    .wr_o(wr), .cache_o(cache), .blast_o(blast), .float_o(flt), .hitm_o(hitm),
    .inval_o(invo), .inval_addr_o(iaddr)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // behavioural model: phase 0 idle, 1 dead clock, 2 strobe, 3 transfer, 4 backed off
  int            m_ph = 0;
  int            m_k  = 0;
  bit            m_hitm = 0, m_inv = 0;
  logic [AW-1:4] m_la = '0;
  logic [31:0]   m_words[$];

  always @(posedge clk) begin
    m_inv = 0;
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_hitm = 0; m_la = '0;
      m_words = '{32'h0, 32'h0, 32'h0, 32'h0};
    end else if (m_ph == 0) begin
      if (snp && hold && inv && hit) begin
        m_ph = 1; m_k = 0; m_hitm = 1; m_la = saddr;
        m_words.delete();
        for (int i = 0; i < 4; i++) m_words.push_back(line[32*i +: 32]);
      end
    end else if (m_ph == 4) begin
      m_k = 0;
      if (!boff) m_ph = 1;
    end else if (boff) begin
      m_ph = 4; m_k = 0;
    end else if (m_ph == 1) m_ph = 2;
    else if (m_ph == 2) m_ph = 3;
    else if (rdy || brdy) begin
      if (m_k == 3) begin
        m_ph = 0; m_hitm = 0; m_inv = 1;
      end else begin
        m_k++;
        if (rdy) m_ph = 2;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!finished) begin
      bit onb;
      onb = (m_ph == 2 || m_ph == 3);
      chk("R1/R7 hitm", hitm, m_hitm);
      chk("R5/R6 ads", ads, m_ph == 2);
      chk("R9 wr", wr, onb);
      chk("R9 cache", cache, onb);
      chk("R8 blast", blast, onb && m_k == 3);
      chk("R10 float", flt, m_ph == 4);
      chk("R11 inval", invo, m_inv);
      if (m_inv) chk("R11 inval addr", iaddr, m_la);
      if (onb) begin
        chk("R3 addr", addr, {m_la, 2'(m_k)});
        chk("R3/R4 data", data, m_words[m_k]);
      end
    end
  end

  task automatic idle_in();
    hold = 0; snp = 0; inv = 0; hit = 0; rdy = 0; brdy = 0; boff = 0;
    saddr = '0; line = '0;
  endtask

  task automatic snoop(bit h, bit iv, bit ht);
    @(negedge clk);
    idle_in();
    hold = h; snp = 1; inv = iv; hit = ht;
    saddr = {$urandom, $urandom} >> 4;
    line = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    snp = 0; line = '0;
  endtask

  task automatic run(int n, bit r, bit b);
    rdy = r; brdy = b;
    repeat (n) @(negedge clk);
    rdy = 0; brdy = 0;
  endtask

  initial begin
    void'($urandom(7));
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;                                   // R1 reset state checked above
    // R2: each missing qualifier leaves the controller idle
    snoop(0, 1, 1); run(4, 1, 1);
    snoop(1, 0, 1); run(4, 1, 1);
    snoop(1, 1, 0); run(4, 1, 1);
    // R4: burst write-back, burst-ready held high
    snoop(1, 1, 1); run(10, 0, 1);
    // R5: plain-ready single transfers
    snoop(1, 1, 1); run(12, 1, 0);
    // R5: both ready types, plain ready wins
    snoop(1, 1, 1); run(12, 1, 1);
    // R10: back-off in the middle of a burst, then restart
    snoop(1, 1, 1); run(3, 0, 1);
    boff = 1; brdy = 1; repeat (3) @(negedge clk); boff = 0; brdy = 0;
    run(10, 0, 1);
    // R2: a snoop during a write-back is ignored
    snoop(1, 1, 1);
    snoop(1, 1, 1); run(10, 0, 1);
    // mixed traffic with wait states, back-off and stray snoops
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      hold  = ($urandom % 4) != 0;
      snp   = ($urandom % 3) == 0;
      inv   = ($urandom % 4) != 0;
      hit   = ($urandom % 2) != 0;
      rdy   = ($urandom % 5) == 0;
      brdy  = ($urandom % 3) == 0;
      boff  = ($urandom % 17) == 0;
      saddr = {$urandom, $urandom} >> 4;
      line  = {$urandom, $urandom, $urandom, $urandom};
    end
    @(negedge clk);
    idle_in();
    repeat (20) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule